// File: doc/BRIEF.md
# Clock Generator Power Sequencer

This block steps a programmable clock generator into and out of its powered-down condition. The generator has a prescaler that divides the oscillator into a master clock and a second divider that divides the master clock into the main output. Both are modelled here as behavioural counters. The sequencer owns every enable in the generator: the oscillator, the external-clock input buffer, the master-clock gate, the drive enables of the main output and the auxiliary output, a strobe that forces both dividers to their largest ratio, and a clear for the output divider.

A power-down request comes from an active-low pin. The pin counts only while a control bit permits it. On a request the main output is first stopped glitch-free while it is low, and the output divider is cleared. The output is then released to high impedance. After that the master clock and the auxiliary output are stopped, and last the oscillator and input buffer. When the request is withdrawn, the oscillator restarts and the sequencer waits for a stable-clock indication. Both dividers are then pinned at maximum for exactly 256 master-clock periods, so that nothing reaches the outputs while the oscillator settles. The programmed ratios are then restored and the outputs are turned on, auxiliary first. Each sequence runs to completion even if the pin changes part way through it.

Top module: `osc_pwr_seq`

## Requirements
- R1: After reset the block is in the running state: `osc_en`, `inbuf_en`, `mclk_gate_en`, `out_drv_en` and `seq_idle` are 1, and `out0_drv_en` equals the inverse of `out0_off_sel`.
- R2: While `pdn_ctl_en` is 0, `pdn_pin` has no effect. While `pdn_pin` is 1 the block stays running. Running means `seq_idle`, `osc_en` and `out_drv_en` stay 1.
- R3: When power-down starts, `div_n_clr` pulses in a cycle in which `out_level` is 0. `out_level` stays 0 from then on, and `out_drv_en` drops only after the pulse while `out_level` is 0.
- R4: `mclk_gate_en` drops exactly one cycle after `out_drv_en` drops. `out0_drv_en` is 0 in that same cycle.
- R5: `osc_en` and `inbuf_en` drop exactly one cycle after `mclk_gate_en`. The block then rests with `seq_idle` at 1 and all enables at 0 for as long as the request stays asserted.
- R6: Once the request is withdrawn, `osc_en` and `inbuf_en` return to 1. `div_force_max` does not pulse until `osc_stable` is 1.
- R7: `out0_drv_en` rises exactly 256 × 2^MW + 2 cycles after the `div_force_max` pulse. This is 256 prescaler periods at maximum ratio, counted from the strobe, plus the reload and enable steps.
- R8: `out_drv_en` rises one cycle after the auxiliary enable step. `seq_idle` rises one cycle after that.
- R9: While `out0_off_sel` is 1, `out0_drv_en` stays 0 in every state.
- R10: If the request is withdrawn during power-down, the block first reaches the powered-down rest (`seq_idle` = 1 with `osc_en` = 0) and then powers up to the running state.
- R11: If the request returns during power-up, the block first reaches the running state and then powers down to rest.
- R12: `seq_idle` is 1 only in the running and powered-down rests. It is 0 in every intermediate step, including the step that waits for the output to go low.
- R13: In the running state after power-up, `out_level` toggles every (m_div + 1) × (n_div + 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_pin | input | 1 | Power-down request, active low |
| pdn_ctl_en | input | 1 | 1 lets the pin request power-down |
| out0_off_sel | input | 1 | 1 keeps the auxiliary output in high impedance |
| m_div | input | MW | Programmed prescaler ratio minus one |
| n_div | input | NW | Programmed output-divider ratio minus one |
| osc_stable | input | 1 | Oscillator reports a stable clock |
| osc_en | output | 1 | Internal oscillator enable |
| inbuf_en | output | 1 | External-clock input buffer enable |
| mclk_gate_en | output | 1 | Master-clock gate |
| mclk_pulse | output | 1 | Gated master-clock tick |
| out_level | output | 1 | Logic level of the main output |
| out_drv_en | output | 1 | Main output drive enable (0 = high impedance) |
| out0_drv_en | output | 1 | Auxiliary output drive enable |
| div_force_max | output | 1 | Strobe forcing both dividers to maximum |
| div_n_clr | output | 1 | Clear strobe for the output divider |
| seq_idle | output | 1 | Sequencer is at rest (running or powered down) |

## Verification
The bench builds the block with a 2-bit prescaler and a 3-bit output divider and keeps the settle counter at its full 8 bits. The maximum-ratio wait is then 1024 cycles, short enough to power up several times in one run while still counting all 256 settle ticks. With these widths, ratios of 3 and 4 give a 12-cycle output half-period. That makes the wait for the output to go low at the start of power-down short, and it can be measured exactly after each restart.

// File: rtl/osc_pwr_pkg.sv
package osc_pwr_pkg;

  typedef enum logic [3:0] {
    S_RUN, S_PD_WLO, S_PD_GATED, S_PD_HIZ, S_PD_NOCLK, S_OFF,
    S_PU_OSC, S_PU_MAX, S_PU_SETTLE, S_PU_LOAD, S_PU_OUT0, S_PU_OUT
  } seq_state_t;

  typedef struct packed {
    logic osc;
    logic inbuf;
    logic mclk;
    logic out_gate;
    logic out_drv;
    logic out0_drv;
  } seq_ctl_t;

  // Enable pattern held in each step of the sequences
  function automatic seq_ctl_t state_ctl(seq_state_t s);
    seq_ctl_t c;
    case (s)
      S_RUN, S_PD_WLO: c = 6'b111111;
      S_PD_GATED:      c = 6'b111011;
      S_PD_HIZ:        c = 6'b111001;
      S_PD_NOCLK:      c = 6'b110000;
      S_OFF:           c = 6'b000000;
      S_PU_OSC:        c = 6'b110000;
      S_PU_MAX, S_PU_SETTLE, S_PU_LOAD: c = 6'b111000;
      S_PU_OUT0:       c = 6'b111001;
      S_PU_OUT:        c = 6'b111011;
      default:         c = 6'b000000;
    endcase
    return c;
  endfunction

  function automatic logic state_is_rest(seq_state_t s);
    return (s == S_RUN) || (s == S_OFF);
  endfunction

  // Settle length in prescaler ticks for a counter width
  function automatic int unsigned settle_ticks(int unsigned w);
    return 1 << w;
  endfunction

endpackage

// File: rtl/osc_div_model.sv
module osc_div_model #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] prog,
  input  logic         force_max,
  input  logic         reload,
  input  logic         clr,
  output logic         tick,
  output logic         level
);
  localparam logic [W-1:0] LIM_MAX = {W{1'b1}};

  logic [W-1:0] cnt;
  logic         hold_max;
  logic [W-1:0] lim;

  assign lim  = hold_max ? LIM_MAX : prog;
  assign tick = en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      hold_max <= 1'b0;
      level    <= 1'b0;
    end else if (force_max) begin
      hold_max <= 1'b1;
      cnt      <= LIM_MAX;
      level    <= 1'b0;
    end else if (reload) begin
      hold_max <= 1'b0;
      cnt      <= prog;
      level    <= 1'b0;
    end else if (clr) begin
      cnt   <= lim;
      level <= 1'b0;
    end else if (en) begin
      if (cnt == '0) begin
        cnt   <= lim;
        level <= ~level;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_MAX_AFTER_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    force_max |=> (cnt == LIM_MAX) && !level); // R7
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  AST_SETTLE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0)); // R7
endmodule

// File: rtl/osc_pwr_seq.sv
module osc_pwr_seq
  import osc_pwr_pkg::*;
#(
  parameter int MW       = 8,
  parameter int NW       = 8,
  parameter int SETTLE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pdn_pin,
  input  logic          pdn_ctl_en,
  input  logic          out0_off_sel,
  input  logic [MW-1:0] m_div,
  input  logic [NW-1:0] n_div,
  input  logic          osc_stable,
  output logic          osc_en,
  output logic          inbuf_en,
  output logic          mclk_gate_en,
  output logic          mclk_pulse,
  output logic          out_level,
  output logic          out_drv_en,
  output logic          out0_drv_en,
  output logic          div_force_max,
  output logic          div_n_clr,
  output logic          seq_idle
);
  seq_state_t state, nxt;
  seq_ctl_t   ctl;

  logic run_req;
  logic m_tick;
  logic m_level;
  logic n_tick;
  logic n_level;
  logic div_reload;
  logic settle_run;
  logic settle_done;

  assign run_req     = !pdn_ctl_en || pdn_pin;
  assign ctl         = state_ctl(state);
  assign settle_run  = (state == S_PU_SETTLE);
  assign div_reload  = (state == S_PU_LOAD);

  assign div_force_max = (state == S_PU_MAX);
  assign div_n_clr     = (state == S_PD_WLO) && !n_level;

  assign osc_en       = ctl.osc;
  assign inbuf_en     = ctl.inbuf;
  assign mclk_gate_en = ctl.mclk;
  assign mclk_pulse   = m_tick && ctl.mclk;
  assign out_level    = n_level && ctl.out_gate;
  assign out_drv_en   = ctl.out_drv;
  assign out0_drv_en  = ctl.out0_drv && !out0_off_sel;
  assign seq_idle     = state_is_rest(state);

  osc_div_model #(.W(MW)) u_mdiv (
    .clk(clk), .rst_n(rst_n), .en(ctl.osc), .prog(m_div),
    .force_max(div_force_max), .reload(div_reload), .clr(1'b0),
    .tick(m_tick), .level(m_level)
  );

  osc_div_model #(.W(NW)) u_ndiv (
    .clk(clk), .rst_n(rst_n), .en(mclk_pulse), .prog(n_div),
    .force_max(div_force_max), .reload(div_reload), .clr(div_n_clr),
    .tick(n_tick), .level(n_level)
  );

  osc_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(settle_run), .tick(m_tick),
    .done(settle_done)
  );

  always_comb begin
    nxt = state;
    case (state)
      S_RUN:       if (!run_req) nxt = S_PD_WLO;
      S_PD_WLO:    if (!n_level) nxt = S_PD_GATED;
      S_PD_GATED:  nxt = S_PD_HIZ;
      S_PD_HIZ:    nxt = S_PD_NOCLK;
      S_PD_NOCLK:  nxt = S_OFF;
      S_OFF:       if (run_req) nxt = S_PU_OSC;
      S_PU_OSC:    if (osc_stable) nxt = S_PU_MAX;
      S_PU_MAX:    nxt = S_PU_SETTLE;
      S_PU_SETTLE: if (settle_done) nxt = S_PU_LOAD;
      S_PU_LOAD:   nxt = S_PU_OUT0;
      S_PU_OUT0:   nxt = S_PU_OUT;
      S_PU_OUT:    nxt = S_RUN;
      default:     nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_RUN;
    else        state <= nxt;
  end

  AST_OUT_LOW_AT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_drv_en) |-> !out_level && !n_level); // R3
  AST_MCLK_AFTER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk_gate_en) |-> !out_drv_en && !out0_drv_en); // R4
  AST_OSC_AFTER_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> !mclk_gate_en && !inbuf_en); // R5
  AST_FORCE_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_force_max |-> osc_en && $past(osc_stable)); // R6
  AST_OUT_AFTER_OUT0: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_drv_en) && !out0_off_sel) |-> out0_drv_en); // R8
  AST_OUT0_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    out0_off_sel |-> !out0_drv_en); // R9
  AST_IDLE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> (out_drv_en == osc_en) && (mclk_gate_en == osc_en)); // R12
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_idle) && !$past(osc_en) && !$past(run_req)) |-> !osc_en); // R5
endmodule

// File: tb/osc_pwr_seq_test.sv
module osc_pwr_seq_test;
  localparam int MW = 2;
  localparam int NW = 3;
  localparam int SW = 8;
  localparam int P  = 1 << MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdn_pin = 1'b1, pdn_ctl_en = 1'b1, out0_off_sel = 1'b0, osc_stable = 1'b1;
  logic [MW-1:0] m_div = 2'd2;
  logic [NW-1:0] n_div = 3'd3;
  logic osc_en, inbuf_en, mclk_gate_en, mclk_pulse, out_level, out_drv_en;
  logic out0_drv_en, div_force_max, div_n_clr, seq_idle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  osc_pwr_seq #(.MW(MW), .NW(NW), .SETTLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .pdn_pin(pdn_pin), .pdn_ctl_en(pdn_ctl_en),
    .out0_off_sel(out0_off_sel), .m_div(m_div), .n_div(n_div),
    .osc_stable(osc_stable), .osc_en(osc_en), .inbuf_en(inbuf_en),
    .mclk_gate_en(mclk_gate_en), .mclk_pulse(mclk_pulse), .out_level(out_level),
    .out_drv_en(out_drv_en), .out0_drv_en(out0_drv_en),
    .div_force_max(div_force_max), .div_n_clr(div_n_clr), .seq_idle(seq_idle)
  );

  // {pdn_ctl_en, pdn_pin, out0_off_sel}: none of these may leave the running state
  localparam logic [2:0] VEC [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic nc();
    @(negedge clk);
  endtask

  function automatic bit running();
    return seq_idle && osc_en && out_drv_en;
  endfunction

  task automatic wait_run(input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      nc();
      if (running()) begin ok = 1; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t_clr, t_hiz, t_mck, t_osc, t_f, t_o0, t_od, t_id, t_e1, t_e2;
    int o0_at_mck, idle_bad, lvl_bad, pre_force;
    bit ok, saw_off, saw_run, o0_seen, prev_lvl;

    repeat (3) nc();
    rst_n = 1'b1;
    nc();
    // R1 reset state
    chk(osc_en && inbuf_en && mclk_gate_en && out_drv_en && seq_idle, "R1", "run enables",
        {osc_en, inbuf_en, mclk_gate_en, out_drv_en, seq_idle}, 5'h1f);
    chk(out0_drv_en == 1'b1, "R1", "out0 drive", out0_drv_en, 1);

    // R2 vector table: pin ignored or high, must stay running
    for (int v = 0; v < 6; v++) begin
      int bad = 0;
      {pdn_ctl_en, pdn_pin, out0_off_sel} = VEC[v];
      for (int k = 0; k < 30; k++) begin
        nc();
        if (!running() || out0_drv_en != !VEC[v][0]) bad++;
      end
      chk(bad == 0, "R2", $sformatf("vector %0d stays running", v), bad, 0);
    end
    pdn_ctl_en = 1'b1; pdn_pin = 1'b1; out0_off_sel = 1'b0;
    repeat (5) nc();

    // Power-down sequence
    t_clr = -1; t_hiz = -1; t_mck = -1; t_osc = -1;
    o0_at_mck = -1; idle_bad = 0; lvl_bad = 0;
    pdn_pin = 1'b0;
    for (int k = 0; k < 300; k++) begin
      nc();
      if (div_n_clr && t_clr < 0) begin
        t_clr = cyc;
        if (out_level) lvl_bad++;
      end
      if (t_clr >= 0 && out_level) lvl_bad++;
      if (!out_drv_en && t_hiz < 0) t_hiz = cyc;
      if (!mclk_gate_en && t_mck < 0) begin t_mck = cyc; o0_at_mck = out0_drv_en; end
      if (!osc_en) begin t_osc = cyc; break; end
      if (seq_idle) idle_bad++;
    end
    chk(t_clr >= 0 && t_hiz > t_clr, "R3", "clear before hi-z", t_hiz - t_clr, 1);
    chk(lvl_bad == 0, "R3", "out low from clear on", lvl_bad, 0);
    chk(t_mck == t_hiz + 1, "R4", "mclk off after hi-z", t_mck - t_hiz, 1);
    chk(o0_at_mck == 0, "R4", "out0 off with mclk", o0_at_mck, 0);
    chk(t_osc == t_mck + 1, "R5", "osc off after mclk", t_osc - t_mck, 1);
    chk(idle_bad == 0, "R12", "idle low mid power-down", idle_bad, 0);
    chk(seq_idle && !inbuf_en, "R5", "rest off", {seq_idle, inbuf_en}, 2);
    begin
      int bad = 0;
      for (int k = 0; k < 20; k++) begin
        nc();
        if (osc_en || inbuf_en || mclk_gate_en || out_drv_en || out0_drv_en || !seq_idle) bad++;
      end
      chk(bad == 0, "R5", "stays off while requested", bad, 0);
    end

    // Power-up, stable indication held low first
    osc_stable = 1'b0;
    pdn_pin = 1'b1;
    pre_force = 0;
    for (int k = 0; k < 10; k++) begin
      nc();
      if (div_force_max) pre_force++;
    end
    chk(osc_en && inbuf_en, "R6", "osc on after release", {osc_en, inbuf_en}, 3);
    chk(pre_force == 0, "R6", "no force before stable", pre_force, 0);
    osc_stable = 1'b1;
    t_f = -1; t_o0 = -1; t_od = -1; t_id = -1; idle_bad = 0;
    for (int k = 0; k < 3000; k++) begin
      nc();
      if (div_force_max && t_f < 0) t_f = cyc;
      if (out0_drv_en && t_o0 < 0) t_o0 = cyc;
      if (out_drv_en && t_od < 0) t_od = cyc;
      if (seq_idle) begin t_id = cyc; break; end
    end
    chk(t_o0 - t_f == 256 * P + 2, "R7", "settle length", t_o0 - t_f, 256 * P + 2);
    chk(t_od == t_o0 + 1, "R8", "out after out0", t_od - t_o0, 1);
    chk(t_id == t_od + 1, "R8", "idle after out", t_id - t_od, 1);

    // R13 programmed ratio restored
    t_e1 = -1; t_e2 = -1;
    prev_lvl = out_level;
    for (int k = 0; k < 100; k++) begin
      nc();
      if (out_level != prev_lvl) begin
        if (t_e1 < 0) t_e1 = cyc; else begin t_e2 = cyc; break; end
      end
      prev_lvl = out_level;
    end
    chk(t_e2 - t_e1 == 12, "R13", "half period", t_e2 - t_e1, 12);

    // R10 release during power-down
    pdn_pin = 1'b0;
    nc();
    pdn_pin = 1'b1;
    saw_off = 0; ok = 0;
    for (int k = 0; k < 3000; k++) begin
      nc();
      if (seq_idle && !osc_en) saw_off = 1;
      if (running()) begin ok = 1; break; end
    end
    chk(saw_off, "R10", "reached off first", saw_off, 1);
    chk(ok, "R10", "then running", ok, 1);

    // R11 and R9: request returns during power-up, out0 held off
    out0_off_sel = 1'b1;
    o0_seen = 0;
    pdn_pin = 1'b0;
    for (int k = 0; k < 300; k++) begin
      nc();
      if (out0_drv_en) o0_seen = 1;
      if (!osc_en) break;
    end
    pdn_pin = 1'b1;
    for (int k = 0; k < 300; k++) begin
      nc();
      if (out0_drv_en) o0_seen = 1;
      if (div_force_max) break;
    end
    repeat (20) nc();
    pdn_pin = 1'b0;
    saw_run = 0; saw_off = 0;
    for (int k = 0; k < 3000; k++) begin
      nc();
      if (out0_drv_en) o0_seen = 1;
      if (running()) saw_run = 1;
      if (seq_idle && !osc_en) begin saw_off = 1; break; end
    end
    chk(saw_run, "R11", "finished power-up first", saw_run, 1);
    chk(saw_off, "R11", "then powered down", saw_off, 1);
    pdn_pin = 1'b1;
    wait_run(3000, ok);
    chk(ok, "R11", "back to running", ok, 1);
    chk(!o0_seen && !out0_drv_en, "R9", "out0 never driven", o0_seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule